// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Core

This block is a minimal 8-bit processor with one working register (the accumulator), a program counter and an instruction register. It sequences a fixed fetch, latch and execute pattern against one external 256-byte memory that holds both program bytes and data bytes. The memory is reached through a plain synchronous port: the core drives an address with a read or a write strobe, and read data comes back one clock later.

The instruction set has three fixed 8-bit opcodes. One increments the accumulator, one decrements it, and one stores the accumulator at the address formed by inverting every bit of the accumulator. Any other byte stops the core and raises a sticky halt flag. The start address and the initial accumulator value are taken from inputs while reset is held.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core loads `pc_value` from `boot_pc` and `acc_value` from `acc_seed`, clears `halted`, and on release its first phase is a fetch with `mem_rd`=1, `mem_wr`=0 and `mem_addr`=`pc_value`.
- R2: A fetch reads the byte at `pc_value`, and at the edge that ends the fetch `pc_value` becomes the fetch address plus one, before the fetched byte is executed.
- R3: Opcode 8'hF0 adds one to the accumulator, modulo 256 (8'hFF becomes 8'h00), with no flags.
- R4: Opcode 8'hF2 subtracts one from the accumulator, modulo 256 (8'h00 becomes 8'hFF), with no flags.
- R5: Opcode 8'h5F writes the accumulator value A to memory address ~A with a one-cycle `mem_wr` pulse and leaves the accumulator unchanged.
- R6: Every defined instruction takes exactly three clock cycles (fetch, latch, execute); `mem_rd` is high only in the fetch cycle and never together with `mem_wr`.
- R7: Any opcode other than 8'hF0, 8'hF2 and 8'h5F sets `halted` one edge after its execute cycle; afterwards the core makes no memory access and `pc_value`, `acc_value` and `halted` stay constant until reset.
- R8: With `boot_pc`=8'h80, `acc_seed`=8'hF2, byte 8'hF0 at 8'h80 and byte 8'h5F at 8'h81, two instructions leave 8'hF3 at address 8'h0C and in the accumulator.
- R9: The program counter wraps from 8'hFF to 8'h00.
- R10: Code and data share one memory: a store that overwrites a not-yet-fetched program byte changes what the core executes there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| boot_pc | input | 8 | Start address loaded into the program counter during reset |
| acc_seed | input | 8 | Value loaded into the accumulator during reset |
| mem_addr | output | 8 | Memory address (program counter on fetch, inverted accumulator on store) |
| mem_rd | output | 1 | Read strobe; data returns on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 8 | Write data (the accumulator) |
| mem_rdata | input | 8 | Read data from the memory, one cycle after mem_rd |
| acc_value | output | 8 | Current accumulator value |
| pc_value | output | 8 | Current program counter value |
| halted | output | 1 | Sticky stop flag for an undefined opcode |

## Verification
Counting from the falling edge at which reset drops, the fetch ends at the first rising edge (program counter advanced), the opcode is captured at the second, and the accumulator update or memory write lands at the third, so each instruction's results are sampled on the falling edge after 3·N rising edges; the halt flag of an undefined opcode is due at that same third edge. All checks sample at falling edges, where registered outputs and the bench memory are settled. A bench reference model executes the same program instruction by instruction and its program counter, accumulator, halt state and full memory image are compared to the design after every scenario.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int unsigned WORD_W = 8;
    localparam int unsigned MEM_BYTES = 1 << WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t OPC_INC   = 8'hF0;
    localparam word_t OPC_DEC   = 8'hF2;
    localparam word_t OPC_STNOT = 8'h5F;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_LATCH = 2'd1,
        PH_EXEC  = 2'd2,
        PH_STOP  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OP_INC   = 2'd0,
        OP_DEC   = 2'd1,
        OP_STORE = 2'd2,
        OP_BAD   = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     acc_we;
        logic     mem_we;
        logic     stop;
    } ctrl_t;

    function automatic ctrl_t decode_byte(word_t op);
        ctrl_t c;
        c = '{kind: OP_BAD, acc_we: 1'b0, mem_we: 1'b0, stop: 1'b1};
        unique case (op)
            OPC_INC:   c = '{kind: OP_INC,   acc_we: 1'b1, mem_we: 1'b0, stop: 1'b0};
            OPC_DEC:   c = '{kind: OP_DEC,   acc_we: 1'b1, mem_we: 1'b0, stop: 1'b0};
            OPC_STNOT: c = '{kind: OP_STORE, acc_we: 1'b0, mem_we: 1'b1, stop: 1'b0};
            default:   c = '{kind: OP_BAD,   acc_we: 1'b0, mem_we: 1'b0, stop: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
    import acc_core_pkg::*;
(
    input  word_t ir,
    output ctrl_t ctrl
);

    always_comb begin
        ctrl = decode_byte(ir);
    end

endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
    import acc_core_pkg::*;
(
    input  word_t    acc,
    input  op_kind_e kind,
    output word_t    acc_next,
    output word_t    store_addr
);

    always_comb begin
        unique case (kind)
            OP_INC:  acc_next = acc + word_t'(1);
            OP_DEC:  acc_next = acc - word_t'(1);
            default: acc_next = acc;
        endcase
        store_addr = ~acc;
    end

endmodule

// File: rtl/acc_core_seq.sv
module acc_core_seq
    import acc_core_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  word_t  boot_pc,
    input  word_t  mem_rdata,
    input  ctrl_t  ctrl,
    output phase_e phase,
    output word_t  pc,
    output word_t  ir,
    output logic   halted
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_FETCH;
            pc     <= boot_pc;
            ir     <= '0;
            halted <= 1'b0;
        end else begin
            unique case (phase)
                PH_FETCH: begin
                    pc    <= pc + word_t'(1);
                    phase <= PH_LATCH;
                end
                PH_LATCH: begin
                    ir    <= mem_rdata;
                    phase <= PH_EXEC;
                end
                PH_EXEC: begin
                    if (ctrl.stop) begin
                        halted <= 1'b1;
                        phase  <= PH_STOP;
                    end else begin
                        phase  <= PH_FETCH;
                    end
                end
                default: phase <= PH_STOP;
            endcase
        end
    end

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R7
    pc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc));

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] boot_pc,
    input  logic [7:0] acc_seed,
    output logic [7:0] mem_addr,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic [7:0] mem_wdata,
    input  logic [7:0] mem_rdata,
    output logic [7:0] acc_value,
    output logic [7:0] pc_value,
    output logic       halted
);

    phase_e phase;
    word_t  pc;
    word_t  ir;
    word_t  acc;
    word_t  acc_next;
    word_t  store_addr;
    ctrl_t  ctrl;
    logic   in_exec;

    acc_core_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .boot_pc   (boot_pc),
        .mem_rdata (mem_rdata),
        .ctrl      (ctrl),
        .phase     (phase),
        .pc        (pc),
        .ir        (ir),
        .halted    (halted)
    );

    acc_core_decode u_dec (
        .ir   (ir),
        .ctrl (ctrl)
    );

    acc_core_alu u_alu (
        .acc        (acc),
        .kind       (ctrl.kind),
        .acc_next   (acc_next),
        .store_addr (store_addr)
    );

    assign in_exec = (phase == PH_EXEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= acc_seed;
        end else if (in_exec && ctrl.acc_we) begin
            acc <= acc_next;
        end
    end

    always_comb begin
        mem_rd    = (phase == PH_FETCH);
        mem_wr    = in_exec && ctrl.mem_we;
        mem_addr  = in_exec ? store_addr : pc;
        mem_wdata = acc;
        acc_value = acc;
        pc_value  = pc;
    end

    // R2
    pc_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (pc_value == $past(mem_addr) + 8'd1));

    // R3
    inc_result_chk: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir == OPC_INC) |=> (acc_value == $past(acc_value) + 8'd1));

    // R4
    dec_result_chk: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir == OPC_DEC) |=> (acc_value == $past(acc_value) - 8'd1));

    // R5
    store_target_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_addr == ~mem_wdata));

    // R5
    store_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> $stable(acc_value));

    // R6
    single_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R6
    rd_wr_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R7
    quiet_halt_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_rd && !mem_wr));

endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] boot_pc = 8'h00;
    logic [7:0] acc_seed = 8'h00;
    logic [7:0] mem_addr;
    logic       mem_rd;
    logic       mem_wr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic [7:0] acc_value;
    logic [7:0] pc_value;
    logic       halted;

    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];
    logic [7:0] ref_pc;
    logic [7:0] ref_acc;
    logic       ref_halt;

    logic       pl_we = 1'b0;
    logic [7:0] pl_addr = 8'h00;
    logic [7:0] pl_data = 8'h00;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_core u_acc_core (
        .clk       (clk),
        .rst       (rst),
        .boot_pc   (boot_pc),
        .acc_seed  (acc_seed),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .acc_value (acc_value),
        .pc_value  (pc_value),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (pl_we) mem[pl_addr] <= pl_data;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        pl_we = 1'b1; pl_addr = a; pl_data = d;
        ref_mem[a] = d;
        @(posedge clk);
        #1 pl_we = 1'b0;
    endtask

    task automatic clear_mem();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 256; i++) poke(8'(i), 8'h00);
    endtask

    task automatic start(input logic [7:0] pc0, input logic [7:0] acc0);
        @(negedge clk);
        rst = 1'b1; boot_pc = pc0; acc_seed = acc0;
        ref_pc = pc0; ref_acc = acc0; ref_halt = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_instr(input int n);
        repeat (3 * n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model_steps(input int n);
        for (int k = 0; k < n; k++) begin
            if (!ref_halt) begin
                logic [7:0] op;
                op = ref_mem[ref_pc];
                ref_pc = ref_pc + 8'd1;
                case (op)
                    8'hF0: ref_acc = ref_acc + 8'd1;
                    8'hF2: ref_acc = ref_acc - 8'd1;
                    8'h5F: ref_mem[~ref_acc] = ref_acc;
                    default: ref_halt = 1'b1;
                endcase
            end
        end
    endtask

    task automatic model_compare(input string tag);
        int bad;
        bad = 0;
        chk({tag, " model pc"}, pc_value, ref_pc);
        chk({tag, " model acc"}, acc_value, ref_acc);
        chk({tag, " model halt"}, {7'd0, halted}, {7'd0, ref_halt});
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
        chk({tag, " model mem mismatches"}, 8'(bad), 8'd0);
    endtask

    task automatic t_example();
        clear_mem();
        poke(8'h80, 8'hF0);
        poke(8'h81, 8'h5F);
        start(8'h80, 8'hF2);
        chk("R1 reset pc", pc_value, 8'h80);
        chk("R1 reset acc", acc_value, 8'hF2);
        chk("R1 reset halted", {7'd0, halted}, 8'd0);
        chk("R1 first fetch rd", {7'd0, mem_rd}, 8'd1);
        chk("R1 first fetch addr", mem_addr, 8'h80);
        chk("R1 no write", {7'd0, mem_wr}, 8'd0);
        @(posedge clk); @(negedge clk);
        chk("R2 pc after fetch", pc_value, 8'h81);
        chk("R2 acc not yet changed", acc_value, 8'hF2);
        chk("R6 rd only in fetch", {7'd0, mem_rd}, 8'd0);
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R3 inc result", acc_value, 8'hF3);
        chk("R6 next fetch after 3 cycles", {7'd0, mem_rd}, 8'd1);
        chk("R6 next fetch addr", mem_addr, 8'h81);
        run_instr(1);
        chk("R8 mem[0C]", mem[8'h0C], 8'hF3);
        chk("R8 acc", acc_value, 8'hF3);
        model_steps(2);
        model_compare("R8");
        run_instr(2);
        model_steps(2);
        model_compare("R7 example end");
    endtask

    task automatic t_wrap();
        clear_mem();
        poke(8'hFF, 8'hF0);
        poke(8'h00, 8'hF2);
        poke(8'h01, 8'hF2);
        start(8'hFF, 8'hFF);
        run_instr(1);
        chk("R3 inc wraps", acc_value, 8'h00);
        chk("R9 pc wraps", pc_value, 8'h00);
        run_instr(1);
        chk("R4 dec wraps", acc_value, 8'hFF);
        run_instr(1);
        chk("R4 dec again", acc_value, 8'hFE);
        model_steps(3);
        model_compare("R9");
    endtask

    task automatic t_store();
        clear_mem();
        poke(8'h40, 8'h5F);
        poke(8'h41, 8'hF2);
        poke(8'h42, 8'h5F);
        start(8'h40, 8'h3C);
        run_instr(1);
        chk("R5 store data", mem[8'hC3], 8'h3C);
        chk("R5 acc kept", acc_value, 8'h3C);
        run_instr(2);
        chk("R5 second store", mem[8'hC4], 8'h3B);
        model_steps(3);
        model_compare("R5");
    endtask

    task automatic t_halt();
        clear_mem();
        poke(8'h10, 8'hF0);
        poke(8'h11, 8'hA5);
        poke(8'h12, 8'hF0);
        start(8'h10, 8'h33);
        run_instr(2);
        chk("R7 halted set", {7'd0, halted}, 8'd1);
        chk("R7 pc at halt", pc_value, 8'h12);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk("R7 halted held", {7'd0, halted}, 8'd1);
        chk("R7 pc frozen", pc_value, 8'h12);
        chk("R7 acc frozen", acc_value, 8'h34);
        chk("R7 no read", {7'd0, mem_rd}, 8'd0);
        chk("R7 no store", mem[8'hCB], 8'h00);
        model_steps(5);
        model_compare("R7");
    endtask

    task automatic t_selfmod();
        clear_mem();
        poke(8'h0E, 8'h5F);
        start(8'h0E, 8'hF0);
        run_instr(1);
        chk("R10 code byte rewritten", mem[8'h0F], 8'hF0);
        run_instr(1);
        chk("R10 rewritten code runs", acc_value, 8'hF1);
        chk("R10 not halted there", {7'd0, halted}, 8'd0);
        run_instr(1);
        chk("R10 halts after", {7'd0, halted}, 8'd1);
        model_steps(3);
        model_compare("R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_example();
        t_wrap();
        t_store();
        t_halt();
        t_selfmod();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule